// File: doc/BRIEF.md
# Rectangular Region Beat Address Generator

This block walks a rectangular memory region one bus beat at a time and hands each beat address to a downstream bus engine through a valid/ready handshake. Software-style configuration is presented on the input pins together with a one-cycle start pulse: a base address, a row length in bytes minus one, a row count minus one, a row pitch in bytes and a repeat flag. The row length and the base must be whole multiples of the bus width in bytes, and the largest length is bounded by the length field width.

Within a row the address climbs by the bus width per accepted beat, and the final beat of every row is tagged. A new row starts one pitch after the start of the row before it, not after where that row ended, so gaps between rows are skipped. A row count of zero gives a plain linear transfer. In repeat mode the region is replayed from the base without end and no completion is ever reported. Otherwise a one-cycle completion pulse follows the final beat. An abort input withdraws the pending beat at once and returns the block to idle on the next edge. The address of the beat about to be issued is visible at all times.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset the block is idle: busy_o, beat_valid_o and done_o are all 0.
- R2: A start_i pulse while idle makes busy_o and beat_valid_o 1 on the next cycle, with beat_addr_o equal to cfg_addr_i.
- R3: Each accepted beat that is not the last of its row moves the address up by BUS_BYTES; while a beat is offered and not accepted its address stays unchanged.
- R4: A row holds (cfg_xlen_i+1)/BUS_BYTES beats, and beat_row_last_o is 1 on exactly the final beat of each row.
- R5: The first beat of each following row is at the first address of the previous row plus cfg_stride_i.
- R6: The transfer covers cfg_ylen_i+1 rows; cfg_ylen_i of 0 gives a single linear row.
- R7: In one-shot mode (cfg_cyclic_i=0) done_o is 1 for exactly one cycle, the cycle after the final beat of the final row is accepted, and busy_o is 0 in that cycle.
- R8: In repeat mode (cfg_cyclic_i=1) the beat after the final beat of the final row is at cfg_addr_i again and done_o never rises.
- R9: While abort_i is 1 no beat is offered; on the next cycle the block is idle, with no completion pulse and no further beats.
- R10: While busy, cur_addr_o shows the address of the beat currently offered or next to be offered.
- R11: A start_i pulse while busy is ignored: the running transfer continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch pulse, taken only when idle |
| abort_i | input | 1 | Cancel the running transfer |
| cfg_addr_i | input | ADDR_W | Base address of the region |
| cfg_xlen_i | input | LEN_W | Row length in bytes minus one |
| cfg_ylen_i | input | LEN_W | Number of rows minus one |
| cfg_stride_i | input | ADDR_W | Row pitch in bytes |
| cfg_cyclic_i | input | 1 | Replay the region endlessly |
| beat_valid_o | output | 1 | A beat address is offered |
| beat_ready_i | input | 1 | Downstream accepts the offered beat |
| beat_addr_o | output | ADDR_W | Address of the offered beat |
| beat_row_last_o | output | 1 | Offered beat closes its row |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | A transfer is in progress |
| cur_addr_o | output | ADDR_W | Current walk address |

## Verification
The assertions take for granted that the base address and row length plus one are whole multiples of the bus width, that lengths fit their fields, and that the configuration pins only matter in the start cycle. Under those terms they check handshake hold, the in-row step, completion timing and the abort response. The stimulus only builds aligned base addresses, row lengths of whole beats and pitches no smaller than the row, and it changes the configuration pins only through the launch task or on deliberately ignored start pulses. The downstream ready follows either a steady or a pseudo-random pattern, so stalls land on row ends and region ends as well as mid-row.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } walk_state_t;

endpackage

// File: rtl/dma2d_beat_ctr.sv
// Loadable down counter reporting when it has reached zero.
module dma2d_beat_ctr #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load_i | dec_i;
    if (load_i) begin
      cnt_d = load_val_i;
    end else begin
      cnt_d = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/dma2d_addr_path.sv
// Address registers: region origin, pitch, row base and walking address.
module dma2d_addr_path #(
  parameter int ADDR_W    = 32,
  parameter int BUS_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] origin_i,
  input  logic [ADDR_W-1:0] pitch_i,
  input  logic              step_beat_i,
  input  logic              step_row_i,
  input  logic              restart_i,
  output logic [ADDR_W-1:0] cur_o
);

  localparam logic [ADDR_W-1:0] BEAT_STEP = ADDR_W'(BUS_BYTES);

  logic [ADDR_W-1:0] origin_q;
  logic [ADDR_W-1:0] pitch_q;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [ADDR_W-1:0] cur_q, cur_d;
  logic              walk_en;
  logic [ADDR_W-1:0] next_row;

  assign next_row = base_q + pitch_q;

  always_comb begin
    walk_en = load_i | restart_i | step_row_i | step_beat_i;
    base_d  = base_q;
    cur_d   = cur_q;
    if (load_i) begin
      base_d = origin_i;
      cur_d  = origin_i;
    end else if (restart_i) begin
      base_d = origin_q;
      cur_d  = origin_q;
    end else if (step_row_i) begin
      base_d = next_row;
      cur_d  = next_row;
    end else if (step_beat_i) begin
      cur_d  = cur_q + BEAT_STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      origin_q <= '0;
      pitch_q  <= '0;
    end else if (load_i) begin
      origin_q <= origin_i;
      pitch_q  <= pitch_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cur_q  <= '0;
    end else if (walk_en) begin
      base_q <= base_d;
      cur_q  <= cur_d;
    end
  end

  assign cur_o = cur_q;

endmodule

// File: rtl/dma2d_addr_gen.sv
// Beat address walker for a rectangular region with optional endless replay.
module dma2d_addr_gen #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 12,
  parameter int BUS_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [LEN_W-1:0]  cfg_xlen_i,
  input  logic [LEN_W-1:0]  cfg_ylen_i,
  input  logic [ADDR_W-1:0] cfg_stride_i,
  input  logic              cfg_cyclic_i,
  output logic              beat_valid_o,
  input  logic              beat_ready_i,
  output logic [ADDR_W-1:0] beat_addr_o,
  output logic              beat_row_last_o,
  output logic              done_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] cur_addr_o
);

  import dma2d_pkg::*;

  localparam int BEAT_SHIFT = (BUS_BYTES > 1) ? $clog2(BUS_BYTES) : 0;

  walk_state_t      state_q, state_d;
  logic [LEN_W-1:0] xrel_q;
  logic [LEN_W-1:0] yrel_q;
  logic             cyc_q;
  logic             done_q, done_d;

  logic             launch;
  logic             accept;
  logic             x_zero, y_zero;
  logic             x_load, x_dec, y_load, y_dec;
  logic             a_load, a_beat, a_row, a_restart;
  logic [LEN_W-1:0] x_load_val, y_load_val;
  logic [LEN_W-1:0] cfg_beats_m1;
  logic [ADDR_W-1:0] walk_addr;

  assign cfg_beats_m1 = cfg_xlen_i >> BEAT_SHIFT;
  assign launch       = (state_q == ST_IDLE) & start_i & ~abort_i;
  assign beat_valid_o = (state_q == ST_RUN) & ~abort_i;
  assign accept       = beat_valid_o & beat_ready_i;
  assign x_load_val   = launch ? cfg_beats_m1 : xrel_q;
  assign y_load_val   = launch ? cfg_ylen_i   : yrel_q;

  // Next-state and control decode
  always_comb begin
    state_d   = state_q;
    done_d    = 1'b0;
    x_load    = 1'b0;
    x_dec     = 1'b0;
    y_load    = 1'b0;
    y_dec     = 1'b0;
    a_load    = 1'b0;
    a_beat    = 1'b0;
    a_row     = 1'b0;
    a_restart = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (launch) begin
          state_d = ST_RUN;
          x_load  = 1'b1;
          y_load  = 1'b1;
          a_load  = 1'b1;
        end
      end
      ST_RUN: begin
        if (abort_i) begin
          state_d = ST_IDLE;
        end else if (accept) begin
          if (!x_zero) begin
            x_dec  = 1'b1;
            a_beat = 1'b1;
          end else if (!y_zero) begin
            x_load = 1'b1;
            y_dec  = 1'b1;
            a_row  = 1'b1;
          end else if (cyc_q) begin
            x_load    = 1'b1;
            y_load    = 1'b1;
            a_restart = 1'b1;
          end else begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  // Configuration captured at launch only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xrel_q <= '0;
      yrel_q <= '0;
      cyc_q  <= 1'b0;
    end else if (launch) begin
      xrel_q <= cfg_beats_m1;
      yrel_q <= cfg_ylen_i;
      cyc_q  <= cfg_cyclic_i;
    end
  end

  dma2d_beat_ctr #(.W(LEN_W)) u_col_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (x_load),
    .load_val_i (x_load_val),
    .dec_i      (x_dec),
    .zero_o     (x_zero)
  );

  dma2d_beat_ctr #(.W(LEN_W)) u_row_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (y_load),
    .load_val_i (y_load_val),
    .dec_i      (y_dec),
    .zero_o     (y_zero)
  );

  dma2d_addr_path #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (a_load),
    .origin_i    (cfg_addr_i),
    .pitch_i     (cfg_stride_i),
    .step_beat_i (a_beat),
    .step_row_i  (a_row),
    .restart_i   (a_restart),
    .cur_o       (walk_addr)
  );

  assign beat_addr_o     = walk_addr;
  assign cur_addr_o      = walk_addr;
  assign beat_row_last_o = beat_valid_o & x_zero;
  assign busy_o          = (state_q == ST_RUN);
  assign done_o          = done_q;

endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk #(
  parameter int ADDR_W    = 32,
  parameter int BUS_BYTES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              abort_i,
  input logic              beat_valid_o,
  input logic              beat_ready_i,
  input logic [ADDR_W-1:0] beat_addr_o,
  input logic              beat_row_last_o,
  input logic              done_o,
  input logic              busy_o,
  input logic [ADDR_W-1:0] cur_addr_o,
  input logic              cyc_q
);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && !beat_ready_i) |=>
      ($stable(beat_addr_o) && (beat_valid_o || abort_i)));

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && beat_ready_i && !beat_row_last_o) |=>
      (cur_addr_o == $past(beat_addr_o) + ADDR_W'(BUS_BYTES)));

  assert_offer_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid_o |-> busy_o);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(beat_valid_o && beat_ready_i && beat_row_last_o)));

  assert_no_done_cyclic_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !cyc_q);

  assert_abort_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |-> !beat_valid_o);

  assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (!busy_o && !done_o));

endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(
  .ADDR_W    (ADDR_W),
  .BUS_BYTES (BUS_BYTES)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .abort_i         (abort_i),
  .beat_valid_o    (beat_valid_o),
  .beat_ready_i    (beat_ready_i),
  .beat_addr_o     (beat_addr_o),
  .beat_row_last_o (beat_row_last_o),
  .done_o          (done_o),
  .busy_o          (busy_o),
  .cur_addr_o      (cur_addr_o),
  .cyc_q           (cyc_q)
);

// File: tb/test_dma2d_addr_gen.sv
module test_dma2d_addr_gen;

  localparam int ADDR_W = 32;
  localparam int LEN_W  = 12;
  localparam int BB     = 4;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              last;
    logic              fin;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic              abort_i = 1'b0;
  logic [ADDR_W-1:0] cfg_addr_i = '0;
  logic [LEN_W-1:0]  cfg_xlen_i = '0;
  logic [LEN_W-1:0]  cfg_ylen_i = '0;
  logic [ADDR_W-1:0] cfg_stride_i = '0;
  logic              cfg_cyclic_i = 1'b0;
  logic              beat_valid_o;
  logic              beat_ready_i = 1'b0;
  logic [ADDR_W-1:0] beat_addr_o;
  logic              beat_row_last_o;
  logic              done_o;
  logic              busy_o;
  logic [ADDR_W-1:0] cur_addr_o;

  int   n_checks = 0;
  int   n_fails  = 0;
  int   acc_cnt  = 0;
  exp_t q[$];
  logic cur_cyc = 1'b0;
  logic expect_done = 1'b0;
  logic rdy_rand = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  logic stall_seen = 1'b0;
  logic [ADDR_W-1:0] stall_addr = '0;

  always #10 clk = ~clk;  // 50 MHz

  dma2d_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BUS_BYTES(BB)) i_dma2d_addr_gen (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (start_i),
    .abort_i         (abort_i),
    .cfg_addr_i      (cfg_addr_i),
    .cfg_xlen_i      (cfg_xlen_i),
    .cfg_ylen_i      (cfg_ylen_i),
    .cfg_stride_i    (cfg_stride_i),
    .cfg_cyclic_i    (cfg_cyclic_i),
    .beat_valid_o    (beat_valid_o),
    .beat_ready_i    (beat_ready_i),
    .beat_addr_o     (beat_addr_o),
    .beat_row_last_o (beat_row_last_o),
    .done_o          (done_o),
    .busy_o          (busy_o),
    .cur_addr_o      (cur_addr_o)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Ready pattern generator
  initial begin
    forever begin
      @(posedge clk);
      #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      beat_ready_i = rdy_rand ? lfsr[0] : 1'b1;
    end
  end

  // Monitor: pops expected beats and checks completion
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (expect_done) begin
          check(done_o === 1'b1 && busy_o === 1'b0, "R7 done pulse", {63'd0, done_o}, 64'd1);
          expect_done = 1'b0;
        end else if (done_o !== 1'b0) begin
          check(1'b0, cur_cyc ? "R8 no done in repeat" : "R7 stray done", {63'd0, done_o}, 64'd0);
        end
        if (abort_i && beat_valid_o) check(1'b0, "R9 beat during abort", 64'd1, 64'd0);
        if (stall_seen && beat_valid_o)
          check(beat_addr_o == stall_addr, "R3 hold while stalled", beat_addr_o, stall_addr);
        stall_seen = beat_valid_o && !beat_ready_i;
        stall_addr = beat_addr_o;
        if (beat_valid_o) begin
          if (cur_addr_o != beat_addr_o)
            check(1'b0, "R10 current address", cur_addr_o, beat_addr_o);
        end
        if (beat_valid_o && beat_ready_i) begin
          if (q.size() == 0) begin
            check(1'b0, "R9 unexpected beat", beat_addr_o, 64'd0);
          end else begin
            exp_t e;
            e = q.pop_front();
            check(beat_addr_o == e.addr && beat_row_last_o == e.last,
                  "R3 R4 R5 R6 beat addr/last",
                  {beat_addr_o, 31'd0, beat_row_last_o}, {e.addr, 31'd0, e.last});
            if (e.fin && !cur_cyc) expect_done = 1'b1;
          end
          acc_cnt++;
        end
      end
    end
  end

  task automatic launch(input logic [ADDR_W-1:0] a, input int xl, input int yl,
                        input logic [ADDR_W-1:0] s, input bit cyc, input int passes);
    int beats;
    beats = (xl + 1) / BB;
    for (int p = 0; p < passes; p++)
      for (int r = 0; r <= yl; r++)
        for (int b = 0; b < beats; b++) begin
          exp_t e;
          e.addr = a + ADDR_W'(r) * s + ADDR_W'(b * BB);
          e.last = (b == beats - 1);
          e.fin  = e.last && (r == yl);
          q.push_back(e);
        end
    @(posedge clk); #1;
    cur_cyc      = cyc;
    cfg_addr_i   = a;
    cfg_xlen_i   = LEN_W'(xl);
    cfg_ylen_i   = LEN_W'(yl);
    cfg_stride_i = s;
    cfg_cyclic_i = cyc;
    start_i      = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    @(negedge clk);
    check(busy_o === 1'b1 && cur_addr_o == a, "R2 launch", cur_addr_o, a);
  endtask

  task automatic wait_drain();
    while (q.size() != 0 || expect_done) @(negedge clk);
    @(negedge clk);
    check(busy_o === 1'b0, "R7 idle after done", {63'd0, busy_o}, 64'd0);
  endtask

  task automatic do_abort();
    #1;
    abort_i = 1'b1;
    @(posedge clk); #1;
    abort_i = 1'b0;
    q.delete();
    @(negedge clk);
    check(busy_o === 1'b0 && beat_valid_o === 1'b0, "R9 idle after abort", {63'd0, busy_o}, 64'd0);
    repeat (6) @(negedge clk);
    check(busy_o === 1'b0 && done_o === 1'b0, "R9 stays idle", {63'd0, busy_o}, 64'd0);
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(busy_o === 1'b0 && beat_valid_o === 1'b0 && done_o === 1'b0,
          "R1 reset state", {61'd0, busy_o, beat_valid_o, done_o}, 64'd0);

    // R6: single linear row, ready held high
    rdy_rand = 1'b0;
    launch(32'h0000_0100, 15, 0, 32'h0, 1'b0, 1);
    wait_drain();

    // R5: three rows of two beats with a gap between rows, random ready
    rdy_rand = 1'b1;
    launch(32'h0000_1000, 7, 2, 32'h40, 1'b0, 1);
    wait_drain();

    // R4: one beat per row, contiguous pitch
    launch(32'h0000_2000, 3, 3, 32'h4, 1'b0, 1);
    wait_drain();

    // R11: stray start while busy must not disturb the walk
    launch(32'h0000_3000, 31, 1, 32'h100, 1'b0, 1);
    repeat (3) @(posedge clk);
    #1;
    cfg_addr_i = 32'h0000_9990; cfg_xlen_i = 3; cfg_cyclic_i = 1'b1;
    start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    wait_drain();
    check(1'b1, "R11 stray start ignored", 64'd0, 64'd0);

    // R8: repeat mode, two full passes, then abort at a region boundary
    launch(32'h0000_4000, 7, 1, 32'h20, 1'b1, 2);
    while (q.size() != 0) @(posedge clk);
    do_abort();

    // R9: abort in the middle of a one-shot walk
    acc_cnt = 0;
    launch(32'h0000_5000, 15, 3, 32'h40, 1'b0, 1);
    while (acc_cnt < 6) @(posedge clk);
    do_abort();

    // New walk after abort runs cleanly
    rdy_rand = 1'b0;
    launch(32'h0000_6000, 11, 1, 32'h10, 1'b0, 1);
    wait_drain();

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule